// File: doc/BRIEF.md
# Fault Enable and Event Register

This block is the fault-status register pair that feeds service-request generation in a remotely programmable instrument. A host command writes an 8-bit enable mask. Seven fault condition levels come in from outside and are sampled on every clock. Each fault whose enable bit is set latches into an 8-bit sticky event register. The block raises a service-request flag while any event bit is held.

The event register is cleared in three ways: by a clearing read, by a clear-status command, or by the power-on reset. The instrument's reset command is not wired to this block, so it disturbs neither register. Bit 0 of both registers is a spare, and its event bit never sets.

The bit meanings are:

| Bit | Meaning |
|-----|---------|
| 7 | enable |
| 6 | output off |
| 5 | shut-off |
| 4 | over-voltage |
| 3 | foldback |
| 2 | over-temperature |
| 1 | AC fail |
| 0 | spare |

Fault input `fault_in[k]` drives event bit `k+1`.

Top module: `fault_srq_regs`

## Requirements
- R1: Event bit 0 (spare) is always 0, whatever mask bit 0 holds and whatever the faults do.
- R2: Event bit k (1..7) sets at a rising clock edge where `fault_in[k-1]` is 1 and mask bit k is 1 before that edge. No event bit sets when its mask bit is 0.
- R3: A set event bit stays set after its fault input returns to 0, until a clearing read, a clear-status or power-on reset.
- R4: While `evt_rd` is 1, `evt_rdata` shows the current event value. At the next edge all eight event bits clear.
- R5: When a clearing read and an enabled fault occur in the same cycle, the returned value does not include the new fault, and that fault's bit is set after the edge.
- R6: A `clr_stat` pulse clears the whole event register at the next edge. Enabled faults present in that cycle set their bits after the clear.
- R8: Power-on reset (`por_n` low, asynchronous) makes the mask 0x00, the event register 0x00 and `srq` 0.
- R9: The mask changes only on an edge with `mask_wr` high, and then takes `mask_wdata`. `mask_rdata` always shows it. With a mask of 0x00 no event bit sets and `srq` stays 0.
- R10: `srq` equals the OR of the event bits as they stood one clock earlier. It rises the clock after the first bit sets and falls the clock after the register clears.
- R11: A fault in the same cycle as a mask write is qualified by the mask held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| fault_in | input | 7 | Fault condition levels, already synchronous; bit k drives event bit k+1 |
| mask_wr | input | 1 | Enable-mask write strobe |
| mask_wdata | input | 8 | New enable mask |
| mask_rdata | output | 8 | Current enable mask |
| evt_rd | input | 1 | Clearing read of the event register |
| evt_rdata | output | 8 | Current event register value |
| clr_stat | input | 1 | Clear-status command, clears the event register |
| srq | output | 1 | Service request, OR of the event bits delayed one clock |

## Verification
The hardest case is the race between a clearing read and a newly enabled fault in the same cycle. It needs a set event bit and a different enabled fault to be live on the exact edge where the read lands. The stimulus first latches one fault and then drops it. It then raises a second enabled fault together with `evt_rd`, and checks that the returned value holds only the old bit while the register afterwards holds only the new one. A mask write that lands together with a fault is reached the same way, to show the old mask still governs that edge.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int REG_W = 8;
  localparam int SPARE_IDX = 0;

  // next state of one sticky event bit: a clear wipes the held value,
  // a qualified fault sets it again after the clear
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return (cur & ~clr) | set;
  endfunction

  // a fault counts only where its enable bit is 1
  function automatic logic qualify(input logic fault, input logic en);
    return fault & en;
  endfunction
endpackage

// File: rtl/fsr_mask_reg.sv
module fsr_mask_reg #(
  parameter int W = fsr_pkg::REG_W
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     mask <= '0;
    else if (wr_en) mask <= wr_data;
  end
endmodule

// File: rtl/fsr_event_bits.sv
module fsr_event_bits #(
  parameter int W     = fsr_pkg::REG_W,
  parameter int SPARE = fsr_pkg::SPARE_IDX
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic [W-1:0] evt
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == SPARE) begin : g_spare
      logic unused_set;
      assign unused_set = set_vec[i];
      assign evt[i] = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) evt[i] <= 1'b0;
        else        evt[i] <= fsr_pkg::sticky_next(evt[i], set_vec[i], clr);
      end
    end
  end
endmodule

// File: rtl/fsr_srq_gen.sv
module fsr_srq_gen #(
  parameter int W = fsr_pkg::REG_W
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] evt,
  output logic         srq
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) srq <= 1'b0;
    else        srq <= |evt;
  end
endmodule

// File: rtl/fault_srq_regs.sv
module fault_srq_regs #(
  parameter int REG_W = fsr_pkg::REG_W
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [REG_W-2:0] fault_in,
  input  logic             mask_wr,
  input  logic [REG_W-1:0] mask_wdata,
  output logic [REG_W-1:0] mask_rdata,
  input  logic             evt_rd,
  output logic [REG_W-1:0] evt_rdata,
  input  logic             clr_stat,
  output logic             srq
);
  localparam int FAULTS = REG_W - 1;

  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] evt_q;
  logic [REG_W-1:0] evt_set;   // qualified faults, bit 0 never driven high
  logic             evt_clr;   // any clearing command this cycle

  fsr_mask_reg #(.W(REG_W)) u_mask (
    .clk     (clk),
    .por_n   (por_n),
    .wr_en   (mask_wr),
    .wr_data (mask_wdata),
    .mask    (mask_q)
  );

  assign evt_set[fsr_pkg::SPARE_IDX] = 1'b0;
  for (genvar k = 0; k < FAULTS; k++) begin : g_qual
    assign evt_set[k+1] = fsr_pkg::qualify(fault_in[k], mask_q[k+1]);
  end

  assign evt_clr = evt_rd | clr_stat;

  fsr_event_bits #(.W(REG_W), .SPARE(fsr_pkg::SPARE_IDX)) u_evt (
    .clk     (clk),
    .por_n   (por_n),
    .set_vec (evt_set),
    .clr     (evt_clr),
    .evt     (evt_q)
  );

  fsr_srq_gen #(.W(REG_W)) u_srq (
    .clk   (clk),
    .por_n (por_n),
    .evt   (evt_q),
    .srq   (srq)
  );

  assign mask_rdata = mask_q;
  assign evt_rdata  = evt_q;
endmodule

// File: rtl/fault_srq_regs_chk.sv
module fault_srq_regs_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         por_n,
  input logic [W-2:0] fault_in,
  input logic         mask_wr,
  input logic [W-1:0] mask_wdata,
  input logic [W-1:0] mask_rdata,
  input logic         evt_rd,
  input logic [W-1:0] evt_rdata,
  input logic         clr_stat,
  input logic         srq
);
  logic armed;
  logic [W-1:0] qual;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end
  assign qual = {fault_in & mask_rdata[W-1:1], 1'b0};

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    evt_rdata[0] == 1'b0);  // R1
  AST_QUAL_SETS: assert property (@(posedge clk) disable iff (!por_n)
    (qual != '0) |=> ((evt_rdata & $past(qual)) == $past(qual)));  // R2
  AST_NO_UNQUAL_SET: assert property (@(posedge clk) disable iff (!por_n)
    armed |=> ((evt_rdata & ~$past(evt_rdata) & ~$past(qual)) == '0));  // R2
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!evt_rd && !clr_stat) |=> ((evt_rdata & $past(evt_rdata)) == $past(evt_rdata)));  // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    evt_rd |=> (evt_rdata == $past(qual)));  // R4
  AST_CLS_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    clr_stat |=> (evt_rdata == $past(qual)));  // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !mask_wr |=> $stable(mask_rdata));  // R9
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    mask_wr |=> (mask_rdata == $past(mask_wdata)));  // R9
  AST_SRQ_LAG: assert property (@(posedge clk) disable iff (!por_n)
    armed |=> (srq == ($past(evt_rdata) != '0)));  // R10
endmodule

bind fault_srq_regs fault_srq_regs_chk #(.W(REG_W)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .fault_in   (fault_in),
  .mask_wr    (mask_wr),
  .mask_wdata (mask_wdata),
  .mask_rdata (mask_rdata),
  .evt_rd     (evt_rd),
  .evt_rdata  (evt_rdata),
  .clr_stat   (clr_stat),
  .srq        (srq)
);

// File: tb/fault_srq_regs_bench.sv
module fault_srq_regs_bench;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [6:0] fault_in = '0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic [7:0] mask_rdata;
  logic       evt_rd = 1'b0;
  logic [7:0] evt_rdata;
  logic       clr_stat = 1'b0;
  logic       srq;

  always #4 clk = ~clk;

  fault_srq_regs u_fault_srq_regs (
    .clk(clk), .por_n(por_n), .fault_in(fault_in), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .mask_rdata(mask_rdata), .evt_rd(evt_rd),
    .evt_rdata(evt_rdata), .clr_stat(clr_stat), .srq(srq)
  );

  typedef struct {
    int         sel;   // 0 mask, 1 event, 2 srq
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_mask = '0;
  logic [7:0] m_evt = '0;
  logic       m_srq = 1'b0;

  // monitor: compare everything queued, half a period after the edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = mask_rdata;
        1: act = evt_rdata;
        default: act = {7'b0, srq};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic push(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_model(input string tag);
    push(0, m_mask, tag);
    push(1, m_evt, tag);
    push(2, {7'b0, m_srq}, tag);
  endtask

  // driver: apply one cycle of inputs, predict the state after the edge
  task automatic cycle(input logic [6:0] f, input logic wr, input logic [7:0] wd,
                       input logic rd, input logic cs, input string tag);
    logic [7:0] nv;
    fault_in = f; mask_wr = wr; mask_wdata = wd; evt_rd = rd; clr_stat = cs;
    expect_model(tag);
    @(posedge clk); #1;
    nv = 8'h00;
    for (int b = 1; b < 8; b++)
      nv[b] = ((rd || cs) ? 1'b0 : m_evt[b]) | (f[b-1] && m_mask[b]);
    m_srq = (m_evt != 8'h00);
    if (wr) m_mask = wd;
    m_evt = nv;
    fault_in = '0; mask_wr = 0; evt_rd = 0; clr_stat = 0;
  endtask

  task automatic idle(input string tag);
    cycle(7'h00, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  task automatic power_on(input string tag);
    por_n = 1'b0; #2;
    m_mask = '0; m_evt = '0; m_srq = 1'b0;
    expect_model(tag);
    @(posedge clk); #1;
    por_n = 1'b1;
  endtask

  initial begin
    #2;
    power_on("R8 reset state");
    idle("R8 idle after reset");

    // mask 0x00: faults ignored
    cycle(7'h7F, 1'b0, 8'h00, 1'b0, 1'b0, "R9 faults with zero mask");
    idle("R9 no event with zero mask");
    push(1, 8'h00, "R9 event stays zero");
    push(2, 8'h00, "R9 srq stays low");

    // write all-ones mask, spare must stay 0
    cycle(7'h00, 1'b1, 8'hFF, 1'b0, 1'b0, "R9 mask write");
    push(0, 8'hFF, "R9 mask readback");
    cycle(7'h7F, 1'b0, 8'h00, 1'b0, 1'b0, "R2 all faults");
    push(1, 8'hFE, "R1 spare bit zero");
    push(2, 8'h00, "R10 srq one cycle late");
    idle("R10 srq rises");
    push(2, 8'h01, "R10 srq high");

    // clearing read
    cycle(7'h00, 1'b0, 8'h00, 1'b1, 1'b0, "R4 read returns value");
    push(1, 8'h00, "R4 cleared by read");
    idle("R10 srq falls next");
    push(2, 8'h00, "R10 srq low");

    // partial mask, sticky
    cycle(7'h00, 1'b1, 8'h12, 1'b0, 1'b0, "R9 mask 0x12");
    cycle(7'h03, 1'b0, 8'h00, 1'b0, 1'b0, "R2 masked pattern");
    push(1, 8'h02, "R2 only enabled bit");
    idle("R3 fault gone");
    idle("R3 still set");
    push(1, 8'h02, "R3 sticky");

    // read races a new enabled fault
    cycle(7'h08, 1'b0, 8'h00, 1'b1, 1'b0, "R5 read with new fault");
    push(1, 8'h10, "R5 new fault kept");
    idle("R5 after race");

    // clear-status
    cycle(7'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R6 clear status");
    push(1, 8'h00, "R6 cleared");
    idle("R6 idle");

    // mask write concurrent with fault uses old mask (0x12)
    cycle(7'h04, 1'b1, 8'h08, 1'b0, 1'b0, "R11 write with fault");
    push(1, 8'h00, "R11 old mask governs");
    cycle(7'h04, 1'b0, 8'h00, 1'b0, 1'b0, "R11 new mask now");
    push(1, 8'h08, "R11 new mask applies");
    idle("R11 idle");

    // clear-status together with a fault
    cycle(7'h04, 1'b0, 8'h00, 1'b0, 1'b1, "R6 clear with fault");
    push(1, 8'h08, "R6 fault set after clear");
    idle("R6 idle2");

    // power-on reset mid-run
    power_on("R8 power-on clears");
    push(0, 8'h00, "R8 mask zero");
    idle("R8 idle");
    idle("R8 end");

    @(negedge clk); #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule